// File: doc/BRIEF.md
# Zero-Run Token Expander

This block turns a compressed byte stream back into its original form. The compressor picks a handful of byte values that seldom occur in the payload and reserves each one to stand for a run of zero bytes of a fixed length. On the decode side, each reserved byte is followed by one of two kinds of byte:

- **A different byte.** The reserved byte becomes that many zero bytes. The following byte is then decoded from scratch, so it can itself be another reserved byte.
- **The same reserved value again.** The pair stands for one literal copy of that value.

Every other byte passes straight through.

Bytes enter and leave on valid/ready handshakes. The output side holds a single register stage. Five token slots each hold a byte value and a 15-bit run length, and they are written through a small write port. Typical slot contents give runs of 2, 3, 4 and 8 zeros, plus one long run of about fifteen thousand.

Top module: `zrun_expand`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1. Every slot has run length 0, so every byte passes through as a literal.
- R2: A slot is written in one cycle by `cfgWe` with `cfgSlot` in 0..4, `cfgToken` and `cfgLen`.
  - A write with `cfgSlot` of 5, 6 or 7 changes nothing.
  - A slot whose run length is 0 is inactive and matches no byte.
- R3: A byte that matches no active slot and is accepted at a clock edge appears on `outData` with `outValid` high right after that edge. Output order equals input order.
- R4: A token byte followed by a byte of a different value produces exactly the slot's run length of zero bytes. The following byte is then decoded normally, and it may itself be a token.
- R5: A token byte followed by the same value produces exactly one output byte equal to that value, and no zeros.
- R6: No input is accepted while a run is being emitted. With the output always ready, the byte after a token of run length L is accepted L+2 cycles after the token.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` stays unchanged. No byte is lost or repeated under any `outReady` pattern.
- R8: When several active slots hold the same token value, the slot with the lowest index sets the run length.
- R9: Run lengths up to 32767 are supported. A 15000-byte run emits exactly 15000 zeros.
- R10: `inReady` is high only when the output register can take a byte in that cycle, that is when `outValid` is 0 or `outReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cfgWe | input | 1 | Slot write strobe |
| cfgSlot | input | 3 | Slot index to write (0..4 valid) |
| cfgToken | input | 8 | Token byte value for the slot |
| cfgLen | input | 15 | Zero-run length for the slot; 0 disables the slot |
| inValid | input | 1 | Compressed byte present |
| inData | input | 8 | Compressed byte |
| inReady | output | 1 | Compressed byte accepted this cycle when high with `inValid` |
| outValid | output | 1 | Expanded byte present |
| outData | output | 8 | Expanded byte |
| outReady | input | 1 | Consumer takes the expanded byte this cycle |

## Verification
A literal, or the second byte of a doubled token, is due on the outputs in the cycle right after its input handshake. A token produces no output in the cycle it is accepted or in the cycle after, and its first zero follows one cycle later still. The next input byte is then taken L+2 cycles after the token.

The bench drives inputs and samples outputs on the falling edge. A byte is counted as delivered only when `outValid` and `outReady` are both high at that sampling point. Delivered bytes are matched in order against a stream computed from the slot model. The directed checks count falling edges between handshakes to confirm the single-cycle literal latency and the L+2 token gap.

// File: rtl/zrun_pkg.sv
package zrun_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2
  } state_t;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic loadLit;   // move inData into the output register
    logic loadZero;  // put a zero byte into the output register
    logic capPend;   // remember the matched token and its slot
    logic loadCnt;   // fetch the run length of the remembered slot
    logic decCnt;    // one zero of the run has been issued
  } strobe_t;

endpackage

// File: rtl/zrun_dp.sv
module zrun_dp
  import zrun_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 15,
  parameter int SLOT_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [DATA_W-1:0] cfgToken,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [DATA_W-1:0] inData,
  input  logic              outReady,
  input  strobe_t           stb,
  output logic              matchAny,
  output logic              matchPend,
  output logic              cntLast,
  output logic              outFree,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0]    tokTab [NUM_SLOTS];
  logic [LEN_W-1:0]     lenTab [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit;
  logic [SLOT_W-1:0]    hitIdx;
  logic [SLOT_W-1:0]    pendSlot;
  logic [DATA_W-1:0]    pendTok;
  logic [LEN_W-1:0]     runCnt;

  // slot table; indices outside 0..NUM_SLOTS-1 select no slot
  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (!rstN) begin
        tokTab[s] <= '0;
        lenTab[s] <= '0;
      end else if (cfgWe && cfgSlot == SLOT_W'(s)) begin
        tokTab[s] <= cfgToken;
        lenTab[s] <= cfgLen;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
      assign hit[g] = (lenTab[g] != '0) && (tokTab[g] == inData);
    end
  endgenerate

  // lowest index wins
  always_comb begin
    hitIdx   = '0;
    matchAny = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hitIdx   = SLOT_W'(i);
        matchAny = 1'b1;
      end
    end
  end

  assign matchPend = (inData == pendTok);
  assign cntLast   = (runCnt == LEN_W'(1));
  assign outFree   = !outValid || outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSlot <= '0;
      pendTok  <= '0;
    end else if (stb.capPend) begin
      pendSlot <= hitIdx;
      pendTok  <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            runCnt <= '0;
    else if (stb.loadCnt) runCnt <= lenTab[pendSlot];
    else if (stb.decCnt)  runCnt <= runCnt - LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (stb.loadLit) begin
      outValid <= 1'b1;
      outData  <= inData;
    end else if (stb.loadZero) begin
      outValid <= 1'b1;
      outData  <= '0;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData)); // R7
  AST_LOAD_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadLit || stb.loadZero) |-> outFree); // R10
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadLit, stb.loadZero, stb.capPend})); // R3
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    stb.decCnt |-> runCnt != '0); // R4

endmodule

// File: rtl/zrun_ctrl.sv
module zrun_ctrl
  import zrun_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    matchAny,
  input  logic    matchPend,
  input  logic    cntLast,
  input  logic    outFree,
  output logic    inReady,
  output strobe_t stb
);

  state_t state, stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    inReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        inReady = outFree;
        if (inValid && outFree) begin
          if (matchAny) begin
            stb.capPend = 1'b1;
            stateNxt    = ST_PEND;
          end else begin
            stb.loadLit = 1'b1;
          end
        end
      end
      ST_PEND: begin
        // a repeated token is consumed; any other byte waits for the run
        inReady = outFree && matchPend;
        if (inValid && outFree) begin
          if (matchPend) begin
            stb.loadLit = 1'b1;
            stateNxt    = ST_IDLE;
          end else begin
            stb.loadCnt = 1'b1;
            stateNxt    = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (outFree) begin
          stb.loadZero = 1'b1;
          stb.decCnt   = 1'b1;
          if (cntLast) stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  AST_RUN_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RUN |-> !inReady); // R6
  AST_PEND_TO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PEND && inValid && outFree && !matchPend |=> state == ST_RUN); // R4
  AST_DOUBLE_LIT: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PEND && inValid && outFree && matchPend |=> state == ST_IDLE); // R5

endmodule

// File: rtl/zrun_expand.sv
module zrun_expand
  import zrun_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 15,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [DATA_W-1:0] cfgToken,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);

  strobe_t stb;
  logic    matchAny;
  logic    matchPend;
  logic    cntLast;
  logic    outFree;

  zrun_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .matchAny  (matchAny),
    .matchPend (matchPend),
    .cntLast   (cntLast),
    .outFree   (outFree),
    .inReady   (inReady),
    .stb       (stb)
  );

  zrun_dp #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .SLOT_W    (SLOT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgSlot   (cfgSlot),
    .cfgToken  (cfgToken),
    .cfgLen    (cfgLen),
    .inData    (inData),
    .outReady  (outReady),
    .stb       (stb),
    .matchAny  (matchAny),
    .matchPend (matchPend),
    .cntLast   (cntLast),
    .outFree   (outFree),
    .outValid  (outValid),
    .outData   (outData)
  );

  AST_READY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!outValid || outReady)); // R10

endmodule

// File: tb/zrun_expand_bench.sv
module zrun_expand_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [2:0]  cfgSlot;
  logic [7:0]  cfgToken;
  logic [14:0] cfgLen;
  logic        inValid;
  logic [7:0]  inData;
  logic        inReady;
  logic        outValid;
  logic [7:0]  outData;
  logic        outReady;

  always #10 clk = ~clk;

  zrun_expand u_zrun_expand (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSlot(cfgSlot),
    .cfgToken(cfgToken), .cfgLen(cfgLen), .inValid(inValid),
    .inData(inData), .inReady(inReady), .outValid(outValid),
    .outData(outData), .outReady(outReady)
  );

  int total = 0;
  int bad   = 0;
  logic [7:0]  mTok [5];
  logic [14:0] mLen [5];
  logic [7:0]  stim [$];
  logic [7:0]  expq [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int findSlot(input logic [7:0] b);
    for (int k = 0; k < 5; k++)
      if (mLen[k] != 0 && mTok[k] == b) return k;
    return -1;
  endfunction

  task automatic buildExp();
    int i = 0;
    expq.delete();
    while (i < stim.size()) begin
      int k = findSlot(stim[i]);
      if (k < 0) begin
        expq.push_back(stim[i]); i++;
      end else if (i + 1 < stim.size() && stim[i+1] == stim[i]) begin
        expq.push_back(stim[i]); i += 2;
      end else begin
        for (int z = 0; z < int'(mLen[k]); z++) expq.push_back(8'h00);
        i++;
      end
    end
  endtask

  task automatic cfg(input int slot, input logic [7:0] tok, input logic [14:0] len);
    @(negedge clk);
    cfgWe = 1'b1; cfgSlot = 3'(slot); cfgToken = tok; cfgLen = len;
    @(negedge clk);
    cfgWe = 1'b0;
    if (slot < 5) begin mTok[slot] = tok; mLen[slot] = len; end
  endtask

  // drives stim, consumes outputs, compares in order against the model
  task automatic runStream(input string req, input int readyPct);
    int idx = 0;
    int cyc = 0;
    int nExp;
    buildExp();
    nExp = expq.size();
    while ((idx < stim.size() || expq.size() != 0) && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      outReady = (int'($urandom % 100) < readyPct);
      inValid  = (idx < stim.size());
      inData   = inValid ? stim[idx] : 8'h00;
      #1;
      if (outValid && outReady) begin
        if (expq.size() == 0) chk(1'b0, req, outData, 0);
        else begin
          logic [7:0] e = expq.pop_front();
          chk(outData == e, req, outData, e);
        end
      end
      if (inValid && inReady) idx++;
    end
    chk(cyc < 60000, {req, " stream stalled"}, cyc, 60000);
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    chk(!outValid, {req, " no extra output"}, outValid, 0);
    chk(expq.size() == 0, {req, " byte count"}, nExp - expq.size(), nExp);
  endtask

  task automatic randStream(input int n);
    logic [7:0] toks [5] = '{8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5};
    stim.delete();
    for (int j = 0; j < n; j++) begin
      int r = int'($urandom % 10);
      if (r < 3) begin
        logic [7:0] t = toks[$urandom % 5];
        stim.push_back(t);
        if ($urandom % 3 == 0) stim.push_back(t);
      end else if (r < 6) stim.push_back(8'($urandom));
      else stim.push_back(8'h00);
    end
    stim.push_back(8'h00);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int gap;
    void'($urandom(32'd4242));
    for (int k = 0; k < 5; k++) begin mTok[k] = 8'h00; mLen[k] = '0; end
    rstN = 1'b0; cfgWe = 1'b0; cfgSlot = '0; cfgToken = '0; cfgLen = '0;
    inValid = 1'b0; inData = '0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    chk(!outValid, "R1 outValid in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1 chk(inReady, "R1 inReady after reset", inReady, 1);

    // R3 single-cycle latency, with no slot configured (R1)
    outReady = 1'b1; inValid = 1'b1; inData = 8'hE1;
    #1 chk(inReady, "R3 ready for literal", inReady, 1);
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid && outData == 8'hE1, "R3 literal one cycle later", outData, 8'hE1);
    @(negedge clk);
    chk(!outValid, "R3 output drained", outValid, 0);

    stim = '{8'hE1, 8'hE2, 8'hE5, 8'h00, 8'h7F};
    runStream("R1 unconfigured pass-through", 70);

    cfg(0, 8'hE1, 15'd2);
    cfg(1, 8'hE2, 15'd3);
    cfg(2, 8'hE3, 15'd4);
    cfg(3, 8'hE4, 15'd8);
    cfg(4, 8'hE5, 15'd300);

    // R6: gap from token to next accepted byte is L+2
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1; inData = 8'hE3;
    #1 chk(inReady, "R6 token accepted", inReady, 1);
    @(negedge clk);
    inData = 8'h33; gap = 1;
    #1;
    while (!inReady && gap < 50) begin
      @(negedge clk); gap++; #1;
    end
    chk(gap == 6, "R6 token-to-next gap", gap, 6);
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);

    stim = '{8'hE2, 8'hE2, 8'hE4, 8'hE4, 8'h05};
    runStream("R5 doubled tokens", 100);

    stim = '{8'hE1, 8'hE2, 8'hE3, 8'h09, 8'hE4, 8'hE1, 8'hE1};
    runStream("R4 token after token", 100);

    for (int p = 0; p < 3; p++) begin
      randStream(250);
      runStream("R7 random backpressure", 35 + 30 * p);
    end

    // R2: out-of-range slot ignored, zero length disables
    cfg(5, 8'h77, 15'd3);
    cfg(7, 8'h78, 15'd3);
    cfg(2, 8'hE3, 15'd0);
    stim = '{8'h77, 8'h01, 8'h78, 8'h02, 8'hE3, 8'h03};
    runStream("R2 ignored writes", 80);
    cfg(2, 8'hE3, 15'd4);

    // R8: duplicate token, lowest slot wins
    cfg(3, 8'hE1, 15'd8);
    stim = '{8'hE1, 8'h44, 8'hAA};
    runStream("R8 lowest slot wins", 90);
    cfg(3, 8'hE4, 15'd8);

    // R9: long run
    cfg(4, 8'hE5, 15'd15000);
    stim = '{8'h11, 8'hE5, 8'h22};
    runStream("R9 long run", 100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule